// File: doc/BRIEF.md
# Saturating Rounding Multiply-Subtract Lane Unit

This block is a packed SIMD datapath. In each signed lane it moves the accumulator up into the high half of a double-width value. It subtracts twice the exact product of two source lanes at full precision. It then rounds the difference back down to lane width, clamps it to the signed lane range and returns it as the new accumulator value. Lanes are 16 or 32 bits wide. An operation covers one 64-bit half, or two halves in 128-bit mode.

The second operand comes in one of two forms. In vector form it is a full vector, lane by lane. In scalar form it is a single element, chosen by an index from the low 64 bits of that input and broadcast to every lane of both halves. Whenever a lane has to be clamped, a sticky flag is set. The flag stays set until the clear input is pulsed. An illegal lane-size code produces an error pulse and no result.

The unit registers its output. It accepts one operation per cycle and delivers the result one cycle after the valid strobe. Register-file access, instruction decode and privilege checks belong to the surrounding pipeline.

Top module: `rdmls_unit`

## Requirements
- R1: With `size_i`=01 (16-bit lanes), lane j occupies bits [16j+15:16j] of every vector. Each result lane equals floor((acc·2^16 − 2·a·b + 2^15) / 2^16), clamped to [−32768, 32767], with all values taken as signed.
- R2: With `size_i`=10 (32-bit lanes), lane j occupies bits [32j+31:32j]. Each result lane equals floor((acc·2^32 − 2·a·b + 2^31) / 2^32), clamped to the signed 32-bit range.
- R3: A lane whose rounded value lies outside the signed lane range is clamped to the nearest end of that range. Both the most positive and the most negative ends are reachable.
- R4: Any clamp in a completed operation sets `sat_o`. The flag then holds until a cycle with `sat_clr_i`=1 clears it. When a clear and a clamping operation fall in the same cycle, the flag ends up set.
- R5: A valid strobe with `size_i` equal to 00 or 11 gives a one-cycle `size_err_o` pulse in the next cycle. It raises no `done_o`, and it leaves `res_o` and `sat_o` unchanged, apart from any clear requested in that cycle.
- R6: With `scalar_i`=1, every lane uses one element of `src_b_i` bits [63:0] as its second operand. For 16-bit lanes the element is lane `index_i` (0 to 3). For 32-bit lanes it is lane `index_i[0]`, and `index_i[1]` is ignored.
- R7: With `scalar_i`=0, lane j of the result uses lane j of `src_b_i` as its second operand.
- R8: With `wide_i`=0, only the lanes in bits [63:0] are computed. `res_o[127:64]` becomes zero, and those upper lanes cannot set `sat_o`.
- R9: `res_o` and `done_o` update on the clock edge that samples a legal valid strobe. `done_o` is high for exactly that one cycle, and `res_o` holds its value until the next legal operation.
- R10: An accumulator of 0 with both sources at the most negative lane value gives exactly the most negative lane value and does not set `sat_o`.
- R11: After reset, `res_o` is zero and `done_o`, `size_err_o` and `sat_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| wide_i | input | 1 | 1: 128-bit operation, 0: low 64 bits only |
| size_i | input | 2 | Lane size: 01 = 16-bit, 10 = 32-bit, others illegal |
| scalar_i | input | 1 | 1: broadcast one element of src_b_i |
| index_i | input | 2 | Element index for the scalar form |
| acc_i | input | 128 | Accumulator vector |
| src_a_i | input | 128 | First source vector |
| src_b_i | input | 128 | Second source vector or scalar holder |
| sat_clr_i | input | 1 | Clears the sticky saturation flag |
| res_o | output | 128 | Registered result vector |
| done_o | output | 1 | One-cycle result strobe |
| size_err_o | output | 1 | One-cycle illegal lane-size pulse |
| sat_o | output | 1 | Sticky saturation flag |

## Verification
Two functions can meet in one cycle: the clear of the sticky flag and a new clamp that sets it. The edge-value sweeps drive `sat_clr_i` together with every operation. After each of those operations the flag must equal whether that operation alone clamped any lane, and the bench works that out from its own wide-integer model. Separate sequences check that the flag stays set across clean operations when no clear is given, and that an idle clear drops it.

// File: rtl/rdmls_pkg.sv
package rdmls_pkg;
  localparam int H_W = 16;
  localparam int W_W = 32;

  typedef enum logic [1:0] {
    LSZ_BAD_LO = 2'b00,
    LSZ_H      = 2'b01,
    LSZ_W      = 2'b10,
    LSZ_BAD_HI = 2'b11
  } lane_sz_e;
endpackage

// File: rtl/rdmls_lane.sv
module rdmls_lane #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] acc_i,
  input  logic signed [W-1:0] a_i,
  input  logic signed [W-1:0] b_i,
  output logic        [W-1:0] res_o,
  output logic                sat_o
);
  localparam int DW = 2 * W + 2;
  localparam logic signed [DW-1:0] RND = DW'(1) << (W - 1);

  logic signed [2*W-1:0] ax, bx, prod;
  logic signed [DW-1:0]  acc_up, prod2, diff;
  logic signed [W+1:0]   hi;
  logic                  fits;

  assign ax     = {{W{a_i[W-1]}}, a_i};
  assign bx     = {{W{b_i[W-1]}}, b_i};
  assign prod   = ax * bx;
  assign acc_up = {{2{acc_i[W-1]}}, acc_i, {W{1'b0}}};
  assign prod2  = {prod[2*W-1], prod, 1'b0};
  assign diff   = acc_up - prod2 + RND;
  assign hi     = (W+2)'(diff >>> W);
  // top three bits agree -> value fits in W signed bits
  assign fits   = (hi[W+1:W-1] == 3'b000) || (hi[W+1:W-1] == 3'b111);

  always_comb begin
    if (fits)        res_o = hi[W-1:0];
    else if (hi[W+1]) res_o = {1'b1, {(W-1){1'b0}}};
    else              res_o = {1'b0, {(W-1){1'b1}}};
  end
  assign sat_o = ~fits;
endmodule

// File: rtl/rdmls_opsel.sv
module rdmls_opsel
  import rdmls_pkg::*;
#(
  parameter int HALF_W = 64,
  parameter int VEC_W  = 128,
  parameter int IDX_W  = 2
) (
  input  logic [VEC_W-1:0] src_b_i,
  input  logic             scalar_i,
  input  logic [IDX_W-1:0] index_i,
  output logic [VEC_W-1:0] b16_o,
  output logic [VEC_W-1:0] b32_o
);
  localparam int N16   = VEC_W / H_W;
  localparam int N32   = VEC_W / W_W;
  localparam int K16   = HALF_W / H_W;
  localparam int K32   = HALF_W / W_W;
  localparam int IDX32 = (K32 > 1) ? $clog2(K32) : 1;

  logic [H_W-1:0] pick16;
  logic [W_W-1:0] pick32;

  always_comb begin
    pick16 = '0;
    for (int k = 0; k < K16; k++)
      if (index_i == IDX_W'(k)) pick16 = src_b_i[k*H_W +: H_W];
  end

  always_comb begin
    pick32 = '0;
    for (int k = 0; k < K32; k++)
      if (index_i[IDX32-1:0] == IDX32'(k)) pick32 = src_b_i[k*W_W +: W_W];
  end

  for (genvar j = 0; j < N16; j++) begin : g_b16
    assign b16_o[j*H_W +: H_W] = scalar_i ? pick16 : src_b_i[j*H_W +: H_W];
  end
  for (genvar j = 0; j < N32; j++) begin : g_b32
    assign b32_o[j*W_W +: W_W] = scalar_i ? pick32 : src_b_i[j*W_W +: W_W];
  end
endmodule

// File: rtl/rdmls_unit.sv
module rdmls_unit
  import rdmls_pkg::*;
#(
  parameter int HALF_W   = 64,
  parameter int NUM_HALF = 2,
  localparam int VEC_W   = HALF_W * NUM_HALF,
  localparam int IDX_W   = $clog2(HALF_W / H_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             wide_i,
  input  logic [1:0]       size_i,
  input  logic             scalar_i,
  input  logic [IDX_W-1:0] index_i,
  input  logic [VEC_W-1:0] acc_i,
  input  logic [VEC_W-1:0] src_a_i,
  input  logic [VEC_W-1:0] src_b_i,
  input  logic             sat_clr_i,
  output logic [VEC_W-1:0] res_o,
  output logic             done_o,
  output logic             size_err_o,
  output logic             sat_o
);
  localparam int N16 = VEC_W / H_W;
  localparam int N32 = VEC_W / W_W;
  localparam int LO16 = HALF_W / H_W;
  localparam int LO32 = HALF_W / W_W;

  lane_sz_e         sz;
  logic             legal, fire;
  logic [VEC_W-1:0] b16, b32, r16, r32, nxt_res;
  logic [N16-1:0]   s16, act16;
  logic [N32-1:0]   s32, act32;
  logic             nxt_sat;

  logic [VEC_W-1:0] res_q;
  logic             done_q, err_q, sat_q;

  assign sz    = lane_sz_e'(size_i);
  assign legal = (sz == LSZ_H) || (sz == LSZ_W);
  assign fire  = valid_i & legal;

  rdmls_opsel #(.HALF_W(HALF_W), .VEC_W(VEC_W), .IDX_W(IDX_W)) u_opsel (
    .src_b_i (src_b_i),
    .scalar_i(scalar_i),
    .index_i (index_i),
    .b16_o   (b16),
    .b32_o   (b32)
  );

  for (genvar j = 0; j < N16; j++) begin : g_l16
    logic [H_W-1:0] r;
    logic           s;
    rdmls_lane #(.W(H_W)) u_lane (
      .acc_i(acc_i[j*H_W +: H_W]),
      .a_i  (src_a_i[j*H_W +: H_W]),
      .b_i  (b16[j*H_W +: H_W]),
      .res_o(r),
      .sat_o(s)
    );
    assign act16[j]           = wide_i || (j < LO16);
    assign r16[j*H_W +: H_W]  = act16[j] ? r : '0;
    assign s16[j]             = act16[j] & s;
  end

  for (genvar j = 0; j < N32; j++) begin : g_l32
    logic [W_W-1:0] r;
    logic           s;
    rdmls_lane #(.W(W_W)) u_lane (
      .acc_i(acc_i[j*W_W +: W_W]),
      .a_i  (src_a_i[j*W_W +: W_W]),
      .b_i  (b32[j*W_W +: W_W]),
      .res_o(r),
      .sat_o(s)
    );
    assign act32[j]           = wide_i || (j < LO32);
    assign r32[j*W_W +: W_W]  = act32[j] ? r : '0;
    assign s32[j]             = act32[j] & s;
  end

  always_comb begin
    if (sz == LSZ_H) begin
      nxt_res = r16;
      nxt_sat = |s16;
    end else begin
      nxt_res = r32;
      nxt_sat = |s32;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      sat_q  <= 1'b0;
    end else begin
      done_q <= fire;
      err_q  <= valid_i & ~legal;
      if (fire) res_q <= nxt_res;
      // a new clamp outranks a clear in the same cycle
      sat_q  <= (sat_q & ~sat_clr_i) | (fire & nxt_sat);
    end
  end

  assign res_o      = res_q;
  assign done_o     = done_q;
  assign size_err_o = err_q;
  assign sat_o      = sat_q;
endmodule

// File: rtl/rdmls_chk.sv
module rdmls_chk #(
  parameter int VEC_W  = 128,
  parameter int HALF_W = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             wide_i,
  input logic [1:0]       size_i,
  input logic             sat_clr_i,
  input logic [VEC_W-1:0] res_o,
  input logic             done_o,
  input logic             size_err_o,
  input logic             sat_o
);
  logic ok_sz;
  assign ok_sz = (size_i == 2'b01) || (size_i == 2'b10);

  assert_done_from_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(valid_i) && ($past(size_i) == 2'b01 || $past(size_i) == 2'b10)));

  assert_done_one_cycle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ok_sz) |=> done_o);

  assert_bad_size_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !ok_sz) |=> (size_err_o && !done_o));

  assert_res_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && ok_sz) |=> $stable(res_o));

  assert_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_o && !sat_clr_i) |=> sat_o);

  assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_clr_i && !valid_i) |=> !sat_o);

  assert_sat_source_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sat_o) |-> done_o);

  assert_upper_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ok_sz && !wide_i) |=> (res_o[VEC_W-1:HALF_W] == '0));
endmodule

bind rdmls_unit rdmls_chk #(.VEC_W(VEC_W), .HALF_W(HALF_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .wide_i    (wide_i),
  .size_i    (size_i),
  .sat_clr_i (sat_clr_i),
  .res_o     (res_o),
  .done_o    (done_o),
  .size_err_o(size_err_o),
  .sat_o     (sat_o)
);

// File: tb/sim_rdmls_unit.sv
`timescale 1ns/1ps
module sim_rdmls_unit;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0, wide_i = 1'b0, scalar_i = 1'b0, sat_clr_i = 1'b0;
  logic [1:0]   size_i = 2'b01, index_i = 2'b00;
  logic [127:0] acc_i = '0, src_a_i = '0, src_b_i = '0;
  logic [127:0] res_o;
  logic         done_o, size_err_o, sat_o;

  int n_vec = 0;
  int n_bad = 0;
  logic [127:0] exp_res = '0;
  bit           exp_flag = 1'b0;

  always #2 clk = ~clk;

  rdmls_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .wide_i(wide_i),
    .size_i(size_i), .scalar_i(scalar_i), .index_i(index_i),
    .acc_i(acc_i), .src_a_i(src_a_i), .src_b_i(src_b_i),
    .sat_clr_i(sat_clr_i), .res_o(res_o), .done_o(done_o),
    .size_err_o(size_err_o), .sat_o(sat_o)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  function automatic logic signed [31:0] lane_of(input logic [127:0] v, input int j, input int w);
    logic [127:0] s;
    s = v >> (j * w);
    if (w == 16) return {{16{s[15]}}, s[15:0]};
    return s[31:0];
  endfunction

  task automatic lane_model(input int w, input logic signed [31:0] c, input logic signed [31:0] a,
                            input logic signed [31:0] b, output logic [31:0] r, output bit s);
    logic signed [79:0] ec, ea, eb, t, mx, mn;
    ec = c; ea = a; eb = b;
    mx = (80'sd1 <<< (w - 1)) - 80'sd1;
    mn = -(80'sd1 <<< (w - 1));
    t = (ec <<< w) - 80'sd2 * ea * eb + (80'sd1 <<< (w - 1));
    t = t >>> w;
    s = 1'b0;
    if (t > mx) begin t = mx; s = 1'b1; end
    else if (t < mn) begin t = mn; s = 1'b1; end
    r = t[31:0];
  endtask

  task automatic op_model(input bit wide, input logic [1:0] sz, input bit scal, input logic [1:0] idx,
                          input logic [127:0] c, input logic [127:0] a, input logic [127:0] b,
                          output logic [127:0] r, output bit s);
    int w, n, bi;
    logic [31:0] rl;
    bit sl;
    w = (sz == 2'b01) ? 16 : 32;
    n = 128 / w;
    r = '0; s = 1'b0;
    for (int j = 0; j < n; j++) begin
      if (!wide && j >= n / 2) continue;
      bi = scal ? ((w == 16) ? int'(idx) : int'(idx[0])) : j;
      lane_model(w, lane_of(c, j, w), lane_of(a, j, w), lane_of(b, bi, w), rl, sl);
      if (w == 16) rl = rl & 32'h0000FFFF;
      r = r | (128'(rl) << (j * w));
      s = s | sl;
    end
  endtask

  task automatic apply(input string req, input bit wide, input logic [1:0] sz, input bit scal,
                       input logic [1:0] idx, input logic [127:0] c, input logic [127:0] a,
                       input logic [127:0] b, input bit clr);
    bit legal, s;
    logic [127:0] r;
    legal = (sz == 2'b01) || (sz == 2'b10);
    @(negedge clk);
    valid_i = 1'b1; wide_i = wide; size_i = sz; scalar_i = scal; index_i = idx;
    acc_i = c; src_a_i = a; src_b_i = b; sat_clr_i = clr;
    if (legal) begin
      op_model(wide, sz, scal, idx, c, a, b, r, s);
      exp_res = r;
    end else s = 1'b0;
    exp_flag = (exp_flag & !clr) | s;
    @(negedge clk);
    valid_i = 1'b0; sat_clr_i = 1'b0;
    check(res_o == exp_res, req, res_o, exp_res);
    check(sat_o == exp_flag, {req, "/R4 flag"}, 128'(sat_o), 128'(exp_flag));
    check(done_o == legal && size_err_o == !legal, {req, "/R9 strobes"},
          {126'd0, done_o, size_err_o}, {126'd0, legal, !legal});
    @(negedge clk);
    check(!done_o && !size_err_o, "R9 pulse width", {126'd0, done_o, size_err_o}, '0);
  endtask

  function automatic logic [31:0] edge_val(input int w, input int i);
    case (i)
      0: return (w == 16) ? 32'h8000 : 32'h80000000;
      1: return (w == 16) ? 32'h8001 : 32'h80000001;
      2: return (w == 16) ? 32'hFFFF : 32'hFFFFFFFF;
      3: return 32'h0;
      4: return 32'h1;
      5: return (w == 16) ? 32'h7FFE : 32'h7FFFFFFE;
      6: return (w == 16) ? 32'h7FFF : 32'h7FFFFFFF;
      default: return (w == 16) ? 32'h4000 : 32'h40000000;
    endcase
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic sweep(input string req, input int w, input logic [1:0] sz);
    int lanes, ops;
    logic [127:0] c, a, b;
    lanes = 128 / w;
    ops = 512 / lanes;
    for (int k = 0; k < ops; k++) begin
      c = '0; a = '0; b = '0;
      for (int l = 0; l < lanes; l++) begin
        int x;
        x = k * lanes + l;
        c = c | (128'(edge_val(w, x / 64)) << (l * w));
        a = a | (128'(edge_val(w, (x / 8) % 8)) << (l * w));
        b = b | (128'(edge_val(w, x % 8)) << (l * w));
      end
      apply(req, 1'b1, sz, 1'b0, 2'd0, c, a, b, 1'b1);
    end
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(res_o == '0 && !done_o && !size_err_o && !sat_o, "R11 reset",
          {res_o[124:0], done_o, size_err_o, sat_o}, '0);

    // R1 / R2 / R3: edge-value sweeps, clear given with each op (same-cycle set vs clear)
    sweep("R1", 16, 2'b01);
    sweep("R2", 32, 2'b10);

    // R3: explicit clamps at both ends
    apply("R3 neg", 1'b1, 2'b01, 1'b0, 2'd0, {8{16'h8000}}, {8{16'h7FFF}}, {8{16'h7FFF}}, 1'b1);
    check(res_o == {8{16'h8000}}, "R3 neg clamp", res_o, {8{16'h8000}});
    apply("R3 pos", 1'b1, 2'b10, 1'b0, 2'd0, {4{32'h7FFFFFFF}}, {4{32'h80000000}}, {4{32'h7FFFFFFF}}, 1'b1);
    check(res_o == {4{32'h7FFFFFFF}} && sat_o, "R3 pos clamp", res_o, {4{32'h7FFFFFFF}});

    // R10: zero accumulator, both sources most negative
    apply("R10 h", 1'b1, 2'b01, 1'b0, 2'd0, '0, {8{16'h8000}}, {8{16'h8000}}, 1'b1);
    check(res_o == {8{16'h8000}} && !sat_o, "R10 h exact", res_o, {8{16'h8000}});
    apply("R10 w", 1'b1, 2'b10, 1'b0, 2'd0, '0, {4{32'h80000000}}, {4{32'h80000000}}, 1'b1);
    check(res_o == {4{32'h80000000}} && !sat_o, "R10 w exact", res_o, {4{32'h80000000}});

    // R6: scalar broadcast, every index, both sizes and modes
    for (int i = 0; i < 4; i++) begin
      apply("R6 h", 1'b1, 2'b01, 1'b1, 2'(i), rnd128(), rnd128(), rnd128(), 1'b1);
      apply("R6 w", 1'b1, 2'b10, 1'b1, 2'(i), rnd128(), rnd128(), rnd128(), 1'b1);
      apply("R6 h64", 1'b0, 2'b01, 1'b1, 2'(i), rnd128(), rnd128(), rnd128(), 1'b1);
    end

    // R8: narrow mode with clamping data only in upper lanes
    apply("R8 clr", 1'b1, 2'b01, 1'b0, 2'd0, '0, '0, '0, 1'b1);
    apply("R8", 1'b0, 2'b01, 1'b0, 2'd0, {{4{16'h8000}}, 64'd0}, {{4{16'h7FFF}}, 64'd0},
          {{4{16'h7FFF}}, 64'd0}, 1'b0);
    check(res_o[127:64] == '0 && !sat_o, "R8 upper", res_o, '0);

    // R4: sticky across clean ops, cleared when idle
    apply("R4 set", 1'b1, 2'b01, 1'b0, 2'd0, {8{16'h7FFF}}, {8{16'h8000}}, {8{16'h7FFF}}, 1'b0);
    apply("R4 hold", 1'b1, 2'b01, 1'b0, 2'd0, '0, '0, '0, 1'b0);
    check(sat_o, "R4 sticky", 128'(sat_o), 128'(1));
    @(negedge clk); sat_clr_i = 1'b1;
    @(negedge clk); sat_clr_i = 1'b0; exp_flag = 1'b0;
    check(!sat_o, "R4 clear", 128'(sat_o), '0);

    // R5: illegal sizes, flag set beforehand so a disturbance would show
    apply("R5 set", 1'b1, 2'b10, 1'b0, 2'd0, {4{32'h80000000}}, {4{32'h7FFFFFFF}}, {4{32'h7FFFFFFF}}, 1'b0);
    apply("R5 00", 1'b1, 2'b00, 1'b0, 2'd0, rnd128(), rnd128(), rnd128(), 1'b0);
    apply("R5 11", 1'b1, 2'b11, 1'b1, 2'd1, rnd128(), rnd128(), rnd128(), 1'b0);

    // R7: random vector form
    for (int i = 0; i < 120; i++) begin
      apply("R7", i[0], (i[1] ? 2'b10 : 2'b01), 1'b0, 2'd0, rnd128(), rnd128(), rnd128(), i[2]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule